// File: doc/BRIEF.md
# Memory-Mapped Character Terminal

This block gives a processor a keyboard-and-display terminal through four word registers on a simple load/store bus. The receive side accepts characters from a keyboard source one cycle at a time and holds the newest one for software. The transmit side passes each stored character to a display sink and then reports itself busy, either for a fixed number of cycles or until the sink acknowledges. Software may poll the Ready bits or enable a level interrupt for each side.

Loading the receive data word consumes the character. Storing to the transmit data word starts output. Both actions take effect at the clock edge that completes the bus cycle. Read data is combinational from registered state while `bus_rd` is high.

The receive side is a two-state machine. It moves RX_EMPTY→RX_FULL when a character arrives (transition *arrive*). It moves RX_FULL→RX_EMPTY on a data load with no arrival in the same cycle (transition *consume*). An arrival while already in RX_FULL keeps the state RX_FULL (transition *refill*). The transmit side is also a two-state machine. It moves TX_IDLE→TX_BUSY on a store to the transmit data word (transition *launch*). It moves TX_BUSY→TX_IDLE when the busy counter reaches zero, or when the sink acknowledges in acknowledge mode (transition *finish*).

Top module: `term_mmio`

## Requirements
- R1: After reset, receive control reads 0, transmit control reads 1 (Ready set, enable clear), `irq` is 0 and `disp_valid` is 0.
- R2: The device window is every address whose upper 16 bits equal those of `BASE_ADDR` (default 0xFFFF0000). The word offsets are 0x0 receive control, 0x4 receive data, 0x8 transmit control and 0xC transmit data. Any other address, including a misaligned one or one outside the window, reads 0, and a write to it changes nothing.
- R3: Control words use bit 0 for Ready and bit 1 for interrupt enable. Receive control also has bit 2 for overrun. All other bits read 0. A store to a control word loads bit 1 from `bus_wdata[1]`.
- R4: A cycle with `kb_valid` high sets receive Ready at the next edge. The receive data word then reads `kb_char` in bits 7:0, with bits 31:8 at 0.
- R5: A load of receive data returns the held character and clears receive Ready. If a character arrives in the same cycle, the load returns the old character, and Ready stays 1 with the new character held.
- R6: An arrival while receive Ready is 1, with no receive-data load in the same cycle, overwrites the character and sets overrun. A read of receive control returns the current overrun value and clears it afterwards, unless an overrun is being set in the same cycle. In that case the set wins.
- R7: A store to transmit data while transmit Ready is 1 raises `disp_valid` for exactly the following cycle, with `disp_char` equal to `bus_wdata[7:0]`, and clears transmit Ready.
- R8: With `TX_ACK_MODE`=0, transmit Ready returns to 1 exactly `TX_BUSY_CYCLES` cycles after the launching store.
- R9: With `TX_ACK_MODE`=1, transmit Ready stays 0 until `disp_ack` is sampled high while busy, and is 1 from the next cycle.
- R10: A store to transmit data while transmit Ready is 0 is dropped. It produces no pulse, leaves `disp_char` unchanged and does not alter the busy timing.
- R11: `irq` is high exactly when (receive Ready and receive enable) or (transmit Ready and transmit enable) is true, as a level.
- R12: Bus stores never change a Ready bit or the overrun bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 32 | Byte address of the bus access |
| bus_rd | input | 1 | Load strobe, one cycle per access |
| bus_wr | input | 1 | Store strobe, one cycle per access |
| bus_wdata | input | 32 | Store data |
| bus_rdata | output | 32 | Load data, valid while bus_rd is high |
| kb_valid | input | 1 | Keyboard character present this cycle |
| kb_char | input | 8 | Keyboard character |
| disp_valid | output | 1 | One-cycle strobe handing a character to the display |
| disp_char | output | 8 | Character for the display |
| disp_ack | input | 1 | Display finished (acknowledge mode only) |
| irq | output | 1 | Level interrupt request |

## Verification
Two receive-side events can fall in one cycle: a keyboard arrival and a software access. The bench places a `kb_valid` pulse in the same cycle as a receive-data load. It judges that the load returned the old character, that Ready is still 1 and overrun is still 0 afterwards, and that the new character can then be read. It also places an arrival on a full receiver in the same cycle as a receive-control read. It expects that read to show overrun 0 and the next control read to show it 1.

// File: rtl/term_pkg.sv
package term_pkg;
    localparam int WORD_W = 32;
    localparam int CHAR_W = 8;

    typedef enum logic [1:0] {
        SEL_RX_CTL  = 2'd0,
        SEL_RX_DATA = 2'd1,
        SEL_TX_CTL  = 2'd2,
        SEL_TX_DATA = 2'd3
    } reg_sel_e;

    typedef enum logic {
        RX_EMPTY = 1'b0,
        RX_FULL  = 1'b1
    } rx_state_e;

    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_BUSY = 1'b1
    } tx_state_e;

    localparam int BIT_READY = 0;
    localparam int BIT_IE    = 1;
    localparam int BIT_OVR   = 2;
endpackage

// File: rtl/term_decode.sv
module term_decode #(
    parameter int                ADDR_W = 32,
    parameter int                WIN_W  = 16,
    parameter logic [ADDR_W-1:0] BASE   = 32'hFFFF_0000
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [3:0]        sel
);
    localparam int TAG_LO = WIN_W;

    logic in_win;
    logic mapped;

    assign in_win = (addr[ADDR_W-1:TAG_LO] == BASE[ADDR_W-1:TAG_LO]);
    assign mapped = in_win && (addr[WIN_W-1:4] == '0) && (addr[1:0] == 2'b00);

    for (genvar g = 0; g < 4; g++) begin : g_sel
        assign sel[g] = mapped && (addr[3:2] == 2'(g));
    end
endmodule

// File: rtl/term_rx_side.sv
module term_rx_side
    import term_pkg::*;
#(
    parameter int CW = CHAR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          kb_valid,
    input  logic [CW-1:0] kb_char,
    input  logic          ctl_wr,
    input  logic          ie_wdata,
    input  logic          ctl_rd,
    input  logic          data_rd,
    output logic          rx_ready,
    output logic          rx_ie,
    output logic          rx_ovr,
    output logic [CW-1:0] rx_char
);
    rx_state_e state_q, state_d;
    logic      ovr_set;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RX_EMPTY;
        else        state_q <= state_d;
    end

    // next state: arrive, consume, refill
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_EMPTY: if (kb_valid) state_d = RX_FULL;
            RX_FULL:  if (!kb_valid && data_rd) state_d = RX_EMPTY;
            default:  state_d = RX_EMPTY;
        endcase
    end

    assign ovr_set = kb_valid && (state_q == RX_FULL) && !data_rd;

    // outputs and held data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_ie   <= 1'b0;
            rx_ovr  <= 1'b0;
            rx_char <= '0;
        end else begin
            if (ctl_wr)        rx_ie   <= ie_wdata;
            if (kb_valid)      rx_char <= kb_char;
            if (ovr_set)       rx_ovr  <= 1'b1;
            else if (ctl_rd)   rx_ovr  <= 1'b0;
        end
    end

    assign rx_ready = (state_q == RX_FULL);
endmodule

// File: rtl/term_tx_side.sv
module term_tx_side
    import term_pkg::*;
#(
    parameter int CW          = CHAR_W,
    parameter int BUSY_CYCLES = 4,
    parameter bit ACK_MODE    = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch_req,
    input  logic [CW-1:0] wchar,
    input  logic          ctl_wr,
    input  logic          ie_wdata,
    input  logic          disp_ack,
    output logic          tx_ready,
    output logic          tx_ie,
    output logic          disp_valid,
    output logic [CW-1:0] disp_char
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES - 1);

    tx_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             launch;
    logic             finish;

    assign launch = launch_req && (state_q == TX_IDLE);
    assign finish = ACK_MODE ? disp_ack : (cnt_q == '0);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    // next state: launch, finish
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: if (launch) state_d = TX_BUSY;
            TX_BUSY: if (finish) state_d = TX_IDLE;
            default: state_d = TX_IDLE;
        endcase
    end

    // busy counter and registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            tx_ie      <= 1'b0;
            disp_valid <= 1'b0;
            disp_char  <= '0;
        end else begin
            disp_valid <= launch;
            if (launch)                                  disp_char <= wchar;
            if (ctl_wr)                                  tx_ie     <= ie_wdata;
            if (launch)                                  cnt_q     <= CNT_LOAD;
            else if (state_q == TX_BUSY && cnt_q != '0)  cnt_q     <= cnt_q - 1'b1;
        end
    end

    assign tx_ready = (state_q == TX_IDLE);
endmodule

// File: rtl/term_mmio.sv
module term_mmio
    import term_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR      = 32'hFFFF_0000,
    parameter int          WIN_W          = 16,
    parameter int          TX_BUSY_CYCLES = 4,
    parameter bit          TX_ACK_MODE    = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] bus_addr,
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        kb_valid,
    input  logic [7:0]  kb_char,
    output logic        disp_valid,
    output logic [7:0]  disp_char,
    input  logic        disp_ack,
    output logic        irq
);
    logic [3:0]        sel;
    logic              rx_ready, rx_ie, rx_ovr;
    logic              tx_ready, tx_ie;
    logic [CHAR_W-1:0] rx_char;

    term_decode #(.ADDR_W(32), .WIN_W(WIN_W), .BASE(BASE_ADDR)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    term_rx_side #(.CW(CHAR_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .kb_valid (kb_valid),
        .kb_char  (kb_char),
        .ctl_wr   (bus_wr && sel[SEL_RX_CTL]),
        .ie_wdata (bus_wdata[BIT_IE]),
        .ctl_rd   (bus_rd && sel[SEL_RX_CTL]),
        .data_rd  (bus_rd && sel[SEL_RX_DATA]),
        .rx_ready (rx_ready),
        .rx_ie    (rx_ie),
        .rx_ovr   (rx_ovr),
        .rx_char  (rx_char)
    );

    term_tx_side #(.CW(CHAR_W), .BUSY_CYCLES(TX_BUSY_CYCLES), .ACK_MODE(TX_ACK_MODE)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch_req (bus_wr && sel[SEL_TX_DATA]),
        .wchar      (bus_wdata[CHAR_W-1:0]),
        .ctl_wr     (bus_wr && sel[SEL_TX_CTL]),
        .ie_wdata   (bus_wdata[BIT_IE]),
        .disp_ack   (disp_ack),
        .tx_ready   (tx_ready),
        .tx_ie      (tx_ie),
        .disp_valid (disp_valid),
        .disp_char  (disp_char)
    );

    // read path
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (sel[SEL_RX_CTL]) begin
                bus_rdata[BIT_READY] = rx_ready;
                bus_rdata[BIT_IE]    = rx_ie;
                bus_rdata[BIT_OVR]   = rx_ovr;
            end
            if (sel[SEL_RX_DATA]) bus_rdata[CHAR_W-1:0] = rx_char;
            if (sel[SEL_TX_CTL]) begin
                bus_rdata[BIT_READY] = tx_ready;
                bus_rdata[BIT_IE]    = tx_ie;
            end
        end
    end

    assign irq = (rx_ready && rx_ie) || (tx_ready && tx_ie);
endmodule

// File: rtl/term_mmio_chk.sv
module term_mmio_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_rd,
    input logic        bus_wr,
    input logic [3:0]  sel,
    input logic [31:0] bus_rdata,
    input logic        kb_valid,
    input logic        rx_ready,
    input logic        rx_ie,
    input logic        rx_ovr,
    input logic        tx_ready,
    input logic        tx_ie,
    input logic        disp_valid,
    input logic        irq
);
    AST_RX_ARRIVE_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        kb_valid |=> rx_ready); // R4

    AST_RX_LOAD_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && sel[1] && !kb_valid) |=> !rx_ready); // R5

    AST_RX_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ovr && !(bus_rd && sel[0])) |=> rx_ovr); // R6

    AST_TX_LAUNCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel[3] && tx_ready) |=> (disp_valid && !tx_ready)); // R7

    AST_TX_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |=> !disp_valid); // R7

    AST_TX_BUSY_STORE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel[3] && !tx_ready) |=> !disp_valid); // R10

    AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && sel == 4'b0000) |-> (bus_rdata == 32'h0)); // R2

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_ie && !tx_ie) |-> !irq); // R11

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel)); // R2
endmodule

bind term_mmio term_mmio_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .sel        (sel),
    .bus_rdata  (bus_rdata),
    .kb_valid   (kb_valid),
    .rx_ready   (rx_ready),
    .rx_ie      (rx_ie),
    .rx_ovr     (rx_ovr),
    .tx_ready   (tx_ready),
    .tx_ie      (tx_ie),
    .disp_valid (disp_valid),
    .irq        (irq)
);

// File: tb/term_mmio_tb.sv
module term_mmio_tb;
    localparam int CLK_PERIOD = 10;
    localparam int BUSY       = 4;
    localparam logic [31:0] A_RXC = 32'hFFFF_0000;
    localparam logic [31:0] A_RXD = 32'hFFFF_0004;
    localparam logic [31:0] A_TXC = 32'hFFFF_0008;
    localparam logic [31:0] A_TXD = 32'hFFFF_000C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        kb_valid = 1'b0;
    logic [7:0]  kb_char = '0;
    logic        disp_ack = 1'b0;
    logic [31:0] rdata, rdata_a;
    logic        dv, dv_a, irq, irq_a;
    logic [7:0]  dc, dc_a;

    int checks = 0;
    int errors = 0;
    logic [31:0] last_a;

    always #(CLK_PERIOD/2) clk = ~clk;

    term_mmio #(.TX_BUSY_CYCLES(BUSY), .TX_ACK_MODE(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata), .kb_valid(kb_valid), .kb_char(kb_char),
        .disp_valid(dv), .disp_char(dc), .disp_ack(disp_ack), .irq(irq));

    term_mmio #(.TX_BUSY_CYCLES(BUSY), .TX_ACK_MODE(1'b1)) u_dut_ack (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_a), .kb_valid(kb_valid), .kb_char(kb_char),
        .disp_valid(dv_a), .disp_char(dc_a), .disp_ack(disp_ack), .irq(irq_a));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one bus cycle: drive at negedge, sample read data, commit at posedge
    task automatic bus_op(input logic rd, input logic wr, input logic [31:0] a,
                          input logic [31:0] d, input logic kv, input logic [7:0] kc,
                          output logic [31:0] rv);
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
        kb_valid = kv; kb_char = kc;
        #1 rv = rdata; last_a = rdata_a;
        @(posedge clk);
        #1 bus_rd = 1'b0; bus_wr = 1'b0; kb_valid = 1'b0;
    endtask

    task automatic rd(input logic [31:0] a, output logic [31:0] v);
        bus_op(1'b1, 1'b0, a, 32'h0, 1'b0, 8'h0, v);
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        logic [31:0] unused_v;
        bus_op(1'b0, 1'b1, a, d, 1'b0, 8'h0, unused_v);
    endtask

    task automatic key(input logic [7:0] c);
        logic [31:0] unused_v;
        bus_op(1'b0, 1'b0, 32'h0, 32'h0, 1'b1, c, unused_v);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 disp_valid", {31'b0, dv}, 32'h0);
        rd(A_RXC, v); check("R1 rx ctl", v, 32'h0);
        rd(A_TXC, v); check("R1 tx ctl", v, 32'h1);
    endtask

    task automatic t_rx_basic();
        logic [31:0] v;
        key(8'h41);
        rd(A_RXC, v); check("R4 ready after arrival", v, 32'h1);
        rd(A_RXD, v); check("R4 data word", v, 32'h41);
        rd(A_RXC, v); check("R5 ready cleared by load", v, 32'h0);
    endtask

    task automatic t_overrun();
        logic [31:0] v;
        key(8'h11); key(8'h22);
        rd(A_RXC, v); check("R6 overrun set", v, 32'h5);
        rd(A_RXC, v); check("R6 overrun cleared by ctl read", v, 32'h1);
        rd(A_RXD, v); check("R6 newest char kept", v, 32'h22);
        rd(A_RXC, v); check("R5 empty after load", v, 32'h0);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        key(8'h33);
        bus_op(1'b1, 1'b0, A_RXD, 32'h0, 1'b1, 8'h44, v);
        check("R5 load beside arrival returns old", v, 32'h33);
        rd(A_RXC, v); check("R5 ready kept, no overrun", v, 32'h1);
        rd(A_RXD, v); check("R5 new char held", v, 32'h44);
        key(8'h55);
        bus_op(1'b1, 1'b0, A_RXC, 32'h0, 1'b1, 8'h66, v);
        check("R6 ctl read beside overrun shows old", v, 32'h1);
        rd(A_RXC, v); check("R6 set wins over clear", v, 32'h5);
        rd(A_RXD, v); check("R6 overwritten char", v, 32'h66);
    endtask

    task automatic t_tx();
        logic [31:0] v;
        int zeros = 0;
        wr(A_TXD, 32'h1234_5678);
        check("R7 pulse", {31'b0, dv}, 32'h1);
        check("R7 char", {24'b0, dc}, 32'h78);
        wr(A_TXD, 32'h0000_0099);
        check("R10 no pulse while busy", {31'b0, dv}, 32'h0);
        check("R10 char unchanged", {24'b0, dc}, 32'h78);
        for (int i = 0; i < 20; i++) begin
            rd(A_TXC, v);
            if (v[0]) break;
            zeros++;
        end
        check("R8 busy length", zeros + 1, BUSY);
        for (int i = 0; i < 6; i++) begin
            rd(A_TXC, v);
        end
        check("R9 still busy without ack", last_a, 32'h0);
        @(negedge clk); disp_ack = 1'b1;
        @(posedge clk); #1 disp_ack = 1'b0;
        rd(A_TXC, v); check("R9 ready after ack", last_a, 32'h1);
    endtask

    task automatic t_ctl_irq();
        logic [31:0] v;
        wr(A_TXC, 32'h0);
        rd(A_TXC, v); check("R12 ready not writable", v, 32'h1);
        wr(A_RXC, 32'hFFFF_FFFF);
        rd(A_RXC, v); check("R3 only enable stored", v, 32'h2);
        check("R11 no irq when rx empty", {31'b0, irq}, 32'h0);
        key(8'h07);
        check("R11 irq on rx ready", {31'b0, irq}, 32'h1);
        rd(A_RXD, v);
        check("R11 irq drops on load", {31'b0, irq}, 32'h0);
        wr(A_TXC, 32'h2);
        check("R11 irq on tx ready", {31'b0, irq}, 32'h1);
        wr(A_TXD, 32'h0000_0021);
        check("R11 irq drops while busy", {31'b0, irq}, 32'h0);
        repeat (BUSY + 2) @(posedge clk);
        #1 check("R11 irq back when idle", {31'b0, irq}, 32'h1);
    endtask

    task automatic t_decode();
        logic [31:0] v;
        wr(A_TXC, 32'h0);
        rd(32'hFFFF_0010, v); check("R2 unmapped in window", v, 32'h0);
        rd(32'hFFFF_0009, v); check("R2 misaligned", v, 32'h0);
        rd(32'h0000_0008, v); check("R2 outside window", v, 32'h0);
        wr(32'h7FFF_000C, 32'h55);
        check("R2 store outside window ignored", {31'b0, dv}, 32'h0);
        wr(32'hFFFF_0018, 32'h2);
        rd(A_TXC, v); check("R2 unmapped store no effect", v, 32'h1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_rx_basic();
        t_overrun();
        t_collide();
        t_tx();
        t_ctl_irq();
        t_decode();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule